// File: doc/BRIEF.md
# Bitmap Frame Buffer with Serial Row Port

This block holds a monochrome image as a 256 by 256 array of single bits. It has three independent ports. A random-access port reads or writes one pixel, addressed by an 8-bit row and an 8-bit column. A fill port paints a rectangle with a constant value, 0 or 1. A transfer port copies a whole row into a wide shift register, which then streams one pixel per enable cycle to a serial video output.

The fill engine paints one complete row of the rectangle per clock, using a column mask. While it runs, the random-access port is held off. The video shifter runs on its own. It can stream pixels while the random port or the fill engine changes the array. A transfer requested while a row is still streaming waits, and is loaded on the cycle the last pixel leaves. Back-to-back rows therefore stream without a gap.

Top module: `vram_bitmap`

## Requirements
- R1: A pixel write with `acc_en`=1 and `acc_we`=1 stores `acc_wdata` at (`acc_row`, `acc_col`). A read with `acc_en`=1 and `acc_we`=0 presents the stored bit on `acc_rdata` one clock later.
- R2: `acc_ready` is low exactly while `fill_busy` is high. An access presented during that time is dropped and leaves the array unchanged.
- R3: A fill sets every pixel with column in `fill_x0`..`fill_x1` and row in `fill_y0`..`fill_y1` (both bounds inclusive) to `fill_val`. All other pixels keep their values.
- R4: `fill_busy` rises the cycle after an accepted `fill_start` and stays high for `fill_y1`-`fill_y0`+1 cycles. `fill_done` is a one-cycle pulse in the first cycle after `fill_busy` falls.
- R5: A start with `fill_x0` > `fill_x1` or `fill_y0` > `fill_y1` gives a one-cycle `fill_err` pulse the next cycle. It does not raise `fill_busy` and does not change the array.
- R6: A `fill_start` received while `fill_busy` is high is ignored.
- R7: A transfer copies row `xfer_row` into the shifter. Each cycle with `shift_en` high emits the next pixel on `vid_out`, with `vid_valid` high one clock later. Pixels leave in column order 0 to 255, which is the shift register's MSB first.
- R8: A transfer requested while pixels remain is held until the last pixel leaves. The new row is then loaded on that same edge, so the old row streams completely and the new one follows with no gap.
- R9: `shift_en` with no pixels loaded gives a one-cycle `underrun` pulse the next cycle, and `vid_valid` stays low.
- R10: Writes to a row after it was transferred do not change the pixels already streaming from the shifter.
- R11: During and right after reset, `fill_busy`, `fill_done`, `fill_err`, `vid_valid` and `underrun` are low and `acc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Random access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | 8 | Pixel row |
| acc_col | input | 8 | Pixel column |
| acc_wdata | input | 1 | Write data |
| acc_ready | output | 1 | Random access can be taken |
| acc_rdata | output | 1 | Read data, one cycle after request |
| fill_start | input | 1 | Start a rectangle fill |
| fill_x0 | input | 8 | First column of rectangle |
| fill_x1 | input | 8 | Last column of rectangle |
| fill_y0 | input | 8 | First row of rectangle |
| fill_y1 | input | 8 | Last row of rectangle |
| fill_val | input | 1 | Value painted |
| fill_busy | output | 1 | Fill in progress |
| fill_done | output | 1 | Fill completed pulse |
| fill_err | output | 1 | Malformed rectangle pulse |
| xfer_req | input | 1 | Request a row transfer to the shifter |
| xfer_row | input | 8 | Row to transfer |
| shift_en | input | 1 | Pixel clock enable |
| vid_out | output | 1 | Serial pixel |
| vid_valid | output | 1 | `vid_out` carries a pixel |
| underrun | output | 1 | Shift requested with nothing loaded |

## Verification
The fill is tried with a series of rectangles: the full screen, a single pixel, one full-width row, a tall column at the right edge and small boxes overlapping earlier ones. Each is followed by a probe pixel just inside or just outside the edges. This separates inclusive-bound errors, off-by-one row walks and value-polarity mistakes, and the busy-cycle count exposes a wrong row range. Streaming is tried with a row pattern that marks column 0, column 1 and column 255, so a reversed order or a shift by one shows up. A second row is queued mid-stream and the streaming row is overwritten mid-stream, which separates an early load, a gap between rows and a shifter that reads the array live.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/fb_fill_engine.sv
module fb_fill_engine
  import fb_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] x0,
  input  logic [COL_W-1:0] x1,
  input  logic [ROW_W-1:0] y0,
  input  logic [ROW_W-1:0] y1,
  input  logic             val,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             wr_en,
  output logic [ROW_W-1:0] wr_row,
  output logic [(1<<COL_W)-1:0] wr_mask,
  output logic             wr_val
);
  localparam int COLS = 1 << COL_W;

  fill_state_e      state_q, state_d;
  logic [ROW_W-1:0] cur_q, cur_d;
  logic [ROW_W-1:0] y0_q, y0_d, y1_q, y1_d;
  logic [COL_W-1:0] x0_q, x0_d, x1_q, x1_d;
  logic             val_q, val_d;
  logic             done_q, done_d, err_q, err_d;
  logic             bad_rect;

  assign bad_rect = (x0 > x1) || (y0 > y1);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    y0_d    = y0_q;
    y1_d    = y1_q;
    x0_d    = x0_q;
    x1_d    = x1_q;
    val_d   = val_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      FILL_IDLE: begin
        if (start) begin
          if (bad_rect) begin
            err_d = 1'b1;
          end else begin
            state_d = FILL_RUN;
            cur_d   = y0;
            y0_d    = y0;
            y1_d    = y1;
            x0_d    = x0;
            x1_d    = x1;
            val_d   = val;
          end
        end
      end
      FILL_RUN: begin
        if (cur_q == y1_q) begin
          state_d = FILL_IDLE;
          done_d  = 1'b1;
        end else begin
          cur_d = cur_q + ROW_W'(1);
        end
      end
      default: state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      cur_q   <= '0;
      y0_q    <= '0;
      y1_q    <= '0;
      x0_q    <= '0;
      x1_q    <= '0;
      val_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      y0_q    <= y0_d;
      y1_q    <= y1_d;
      x0_q    <= x0_d;
      x1_q    <= x1_d;
      val_q   <= val_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  for (genvar gc = 0; gc < COLS; gc++) begin : g_mask
    assign wr_mask[gc] = (x0_q <= COL_W'(gc)) && (COL_W'(gc) <= x1_q);
  end

  assign busy   = (state_q == FILL_RUN);
  assign done   = done_q;
  assign err    = err_q;
  assign wr_en  = busy;
  assign wr_row = cur_q;
  assign wr_val = val_q;

  // R4: completion pulse never overlaps the busy window
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5: a rejected rectangle never starts a walk
  assert_err_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R3: the walk stays inside the latched row range
  assert_row_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_q >= y0_q) && (cur_q <= y1_q));
  // R3: consecutive busy cycles visit consecutive rows
  assert_row_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cur_q == $past(cur_q) + ROW_W'(1)));
endmodule

// File: rtl/fb_row_shifter.sv
module fb_row_shifter #(
  parameter int ROW_W = 8,
  parameter int COLS  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_req,
  input  logic [ROW_W-1:0] xfer_row,
  input  logic             shift_en,
  input  logic [COLS-1:0]  row_data,
  output logic [ROW_W-1:0] load_row,
  output logic             vid_out,
  output logic             vid_valid,
  output logic             underrun
);
  localparam int CNT_W = $clog2(COLS + 1);

  logic             pend_q, pend_d;
  logic [ROW_W-1:0] prow_q, prow_d;
  logic [COLS-1:0]  sreg_q, sreg_d, row_rev;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vout_q, vout_d, vval_q, vval_d, unr_q, unr_d;
  logic             load, emit, empty;

  for (genvar gc = 0; gc < COLS; gc++) begin : g_rev
    assign row_rev[COLS-1-gc] = row_data[gc];
  end

  assign empty = (cnt_q == '0);
  assign emit  = shift_en && !empty;
  assign load  = pend_q && (empty || (emit && cnt_q == CNT_W'(1)));

  always_comb begin
    pend_d = pend_q;
    prow_d = prow_q;
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (xfer_req) begin
      pend_d = 1'b1;
      prow_d = xfer_row;
    end else if (load) begin
      pend_d = 1'b0;
    end
    if (load) begin
      sreg_d = row_rev;
      cnt_d  = CNT_W'(COLS);
    end else if (emit) begin
      sreg_d = {sreg_q[COLS-2:0], 1'b0};
      cnt_d  = cnt_q - CNT_W'(1);
    end
    vout_d = emit ? sreg_q[COLS-1] : 1'b0;
    vval_d = emit;
    unr_d  = shift_en && empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prow_q <= '0;
      sreg_q <= '0;
      cnt_q  <= '0;
      vout_q <= 1'b0;
      vval_q <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      prow_q <= prow_d;
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      vout_q <= vout_d;
      vval_q <= vval_d;
      unr_q  <= unr_d;
    end
  end

  assign load_row  = prow_q;
  assign vid_out   = vout_q;
  assign vid_valid = vval_q;
  assign underrun  = unr_q;

  // R7: a pixel only appears after a shift enable
  assert_valid_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> $past(shift_en));
  // R9: an underrun cycle carries no pixel
  assert_underrun_no_pixel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !vid_valid);
  // R8: the remaining count never exceeds one row
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(COLS));
endmodule

// File: rtl/vram_bitmap.sv
module vram_bitmap #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  input  logic             acc_wdata,
  output logic             acc_ready,
  output logic             acc_rdata,
  input  logic             fill_start,
  input  logic [COL_W-1:0] fill_x0,
  input  logic [COL_W-1:0] fill_x1,
  input  logic [ROW_W-1:0] fill_y0,
  input  logic [ROW_W-1:0] fill_y1,
  input  logic             fill_val,
  output logic             fill_busy,
  output logic             fill_done,
  output logic             fill_err,
  input  logic             xfer_req,
  input  logic [ROW_W-1:0] xfer_row,
  input  logic             shift_en,
  output logic             vid_out,
  output logic             vid_valid,
  output logic             underrun
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [COLS-1:0]  mem [ROWS];
  logic             f_wr_en, f_wr_val;
  logic [ROW_W-1:0] f_wr_row, load_row;
  logic [COLS-1:0]  f_wr_mask, f_fill_bits;
  logic             acc_take;
  logic             rdata_q, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fb_fill_engine #(.ROW_W(ROW_W), .COL_W(COL_W)) i_fill (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (fill_start),
    .x0     (fill_x0),
    .x1     (fill_x1),
    .y0     (fill_y0),
    .y1     (fill_y1),
    .val    (fill_val),
    .busy   (fill_busy),
    .done   (fill_done),
    .err    (fill_err),
    .wr_en  (f_wr_en),
    .wr_row (f_wr_row),
    .wr_mask(f_wr_mask),
    .wr_val (f_wr_val)
  );

  fb_row_shifter #(.ROW_W(ROW_W), .COLS(COLS)) i_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .xfer_req (xfer_req),
    .xfer_row (xfer_row),
    .shift_en (shift_en),
    .row_data (mem[load_row]),
    .load_row (load_row),
    .vid_out  (vid_out),
    .vid_valid(vid_valid),
    .underrun (underrun)
  );

  assign acc_ready   = !fill_busy;
  assign acc_take    = acc_en && acc_ready;
  assign f_fill_bits = f_wr_val ? f_wr_mask : '0;

  always_ff @(posedge clk) begin
    if (f_wr_en) begin
      mem[f_wr_row] <= (mem[f_wr_row] & ~f_wr_mask) | f_fill_bits;
    end else if (acc_take && acc_we) begin
      mem[acc_row][acc_col] <= acc_wdata;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (acc_take && !acc_we) rdata_d = mem[acc_row][acc_col];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= 1'b0;
    else            rdata_q <= rdata_d;
  end
  assign acc_rdata = rdata_q;

  // R2: a held-off read leaves the returned data untouched
  assert_read_stalled_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(fill_busy) |-> $stable(acc_rdata));
endmodule

// File: tb/test_vram_bitmap.sv
module test_vram_bitmap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam int T_X0 [NV] = '{10,  0, 12, 255, 30,   0, 100};
  localparam int T_X1 [NV] = '{20,  0, 14, 255, 40, 255, 101};
  localparam int T_Y0 [NV] = '{ 5,  0,  6, 100, 50, 200,  10};
  localparam int T_Y1 [NV] = '{ 7,  0,  6, 255, 50, 200,  11};
  localparam int T_V  [NV] = '{ 1,  1,  0,   1,  1,   1,   0};
  localparam int T_PR [NV] = '{ 6,  0,  6, 255, 50, 200,   6};
  localparam int T_PC [NV] = '{15,  0, 13, 255, 29, 128,  10};
  localparam int T_EX [NV] = '{ 1,  1,  0,   1,  0,   1,   1};

  logic clk = 1'b0;
  logic rst_n;
  logic acc_en, acc_we, acc_wdata, acc_ready, acc_rdata;
  logic [7:0] acc_row, acc_col;
  logic fill_start, fill_val, fill_busy, fill_done, fill_err;
  logic [7:0] fill_x0, fill_x1, fill_y0, fill_y1;
  logic xfer_req, shift_en, vid_out, vid_valid, underrun;
  logic [7:0] xfer_row;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_bitmap i_vram_bitmap (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_we(acc_we), .acc_row(acc_row), .acc_col(acc_col),
    .acc_wdata(acc_wdata), .acc_ready(acc_ready), .acc_rdata(acc_rdata),
    .fill_start(fill_start), .fill_x0(fill_x0), .fill_x1(fill_x1),
    .fill_y0(fill_y0), .fill_y1(fill_y1), .fill_val(fill_val),
    .fill_busy(fill_busy), .fill_done(fill_done), .fill_err(fill_err),
    .xfer_req(xfer_req), .xfer_row(xfer_row), .shift_en(shift_en),
    .vid_out(vid_out), .vid_valid(vid_valid), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_pix(input int r, input int c, input bit d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_row = 8'(r); acc_col = 8'(c); acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd_pix(input int r, input int c, output bit d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_row = 8'(r); acc_col = 8'(c);
    @(negedge clk);
    acc_en = 1'b0;
    d = acc_rdata;
  endtask

  task automatic start_fill(input int x0, input int x1, input int y0, input int y1, input bit v);
    @(negedge clk);
    fill_x0 = 8'(x0); fill_x1 = 8'(x1); fill_y0 = 8'(y0); fill_y1 = 8'(y1);
    fill_val = v; fill_start = 1'b1;
    @(negedge clk);
    fill_start = 1'b0;
  endtask

  task automatic wait_fill(output int cyc, output bit dn);
    cyc = 0;
    while (fill_busy && cyc < 400) begin
      cyc++;
      @(negedge clk);
    end
    dn = fill_done;
  endtask

  function automatic bit exp40(input int c);
    return (c == 0) || (c == 1) || (c == 255);
  endfunction
  function automatic bit exp41(input int c);
    return (c == 5) || (c == 254);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    bit d, dn, errp;
    int cyc, mism, nval;
    bit got [512];
    rst_n = 1'b0;
    acc_en = 0; acc_we = 0; acc_row = 0; acc_col = 0; acc_wdata = 0;
    fill_start = 0; fill_val = 0; fill_x0 = 0; fill_x1 = 0; fill_y0 = 0; fill_y1 = 0;
    xfer_req = 0; xfer_row = 0; shift_en = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!fill_busy && !fill_done && !fill_err, "R11 fill flags in reset", fill_busy, 0);
    check(!vid_valid && !underrun && acc_ready, "R11 video flags in reset", vid_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!fill_busy && acc_ready && !underrun, "R11 after release", fill_busy, 0);

    // R9: shifting with nothing loaded
    shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    check(underrun == 1'b1, "R9 underrun pulse", underrun, 1);
    check(vid_valid == 1'b0, "R9 no pixel", vid_valid, 0);

    // R3/R4: clear whole screen
    start_fill(0, 255, 0, 255, 1'b0);
    wait_fill(cyc, dn);
    check(cyc == 256, "R4 full-screen busy cycles", cyc, 256);
    check(dn == 1'b1, "R4 done pulse", dn, 1);
    @(negedge clk);
    check(fill_done == 1'b0, "R4 done one cycle", fill_done, 0);

    // R3/R4: table of rectangles with probes
    for (int i = 0; i < NV; i++) begin
      start_fill(T_X0[i], T_X1[i], T_Y0[i], T_Y1[i], 1'(T_V[i]));
      wait_fill(cyc, dn);
      check(cyc == T_Y1[i] - T_Y0[i] + 1, "R4 busy cycles", cyc, T_Y1[i] - T_Y0[i] + 1);
      check(dn == 1'b1, "R4 done after fill", dn, 1);
      rd_pix(T_PR[i], T_PC[i], d);
      check(d == 1'(T_EX[i]), "R3 probe pixel", d, T_EX[i]);
    end

    // R1: random write and read back
    wr_pix(3, 4, 1'b1);
    rd_pix(3, 4, d);
    check(d == 1'b1, "R1 write one", d, 1);
    wr_pix(3, 4, 1'b0);
    rd_pix(3, 4, d);
    check(d == 1'b0, "R1 write zero", d, 0);

    // R5: malformed rectangle
    start_fill(20, 10, 5, 7, 1'b0);
    errp = fill_err;
    check(errp == 1'b1, "R5 error pulse", errp, 1);
    check(fill_busy == 1'b0, "R5 no busy", fill_busy, 0);
    start_fill(10, 20, 7, 5, 1'b0);
    check(fill_err == 1'b1 && !fill_busy, "R5 row order error", fill_err, 1);
    rd_pix(6, 15, d);
    check(d == 1'b1, "R5 memory unchanged", d, 1);

    // R6: second start while busy is ignored
    start_fill(0, 3, 60, 69, 1'b1);
    fill_x0 = 8'd5; fill_x1 = 8'd5; fill_y0 = 8'd60; fill_y1 = 8'd60;
    fill_start = 1'b1;
    @(negedge clk);
    fill_start = 1'b0;
    wait_fill(cyc, dn);
    check(cyc == 9, "R6 busy unchanged by second start", cyc, 9);
    rd_pix(60, 5, d);
    check(d == 1'b0, "R6 ignored rectangle", d, 0);
    rd_pix(69, 3, d);
    check(d == 1'b1, "R3 corner of first rectangle", d, 1);

    // R2: access during fill is dropped
    start_fill(0, 7, 80, 83, 1'b1);
    check(acc_ready == 1'b0, "R2 ready low while busy", acc_ready, 0);
    acc_en = 1'b1; acc_we = 1'b1; acc_row = 8'd70; acc_col = 8'd70; acc_wdata = 1'b1;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
    wait_fill(cyc, dn);
    check(acc_ready == 1'b1, "R2 ready after fill", acc_ready, 1);
    rd_pix(70, 70, d);
    check(d == 1'b0, "R2 stalled write dropped", d, 0);

    // rows for streaming
    wr_pix(40, 0, 1'b1); wr_pix(40, 1, 1'b1); wr_pix(40, 255, 1'b1);
    wr_pix(41, 5, 1'b1); wr_pix(41, 254, 1'b1);

    // R7/R8/R10: stream row 40, queue row 41 mid-stream, overwrite row 40
    @(negedge clk);
    xfer_req = 1'b1; xfer_row = 8'd40;
    @(negedge clk);
    xfer_req = 1'b0;
    for (int k = 0; k <= 512; k++) begin
      @(negedge clk);
      if (k > 0) begin
        got[k-1] = vid_out;
        if (vid_valid) nval++;
      end
      shift_en = (k < 512);
      xfer_req = (k == 10);
      xfer_row = 8'd41;
      acc_en = (k == 20); acc_we = (k == 20);
      acc_row = 8'd40; acc_col = 8'd255; acc_wdata = 1'b0;
    end
    shift_en = 1'b0; xfer_req = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
    check(got[0] == 1'b1 && got[2] == 1'b0, "R7 column 0 first", got[2], 0);
    check(got[1] == 1'b1, "R7 column order", got[1], 1);
    mism = 0;
    for (int c = 0; c < 256; c++) begin
      if (got[c] != exp40(c)) mism++;
      if (got[256+c] != exp41(c)) mism++;
    end
    check(mism == 0, "R8 back-to-back rows", mism, 0);
    check(nval == 512, "R8 no gap in valid", nval, 512);
    check(got[255] == 1'b1, "R10 shifted pixel unaffected by write", got[255], 1);
    rd_pix(40, 255, d);
    check(d == 1'b0, "R10 array updated by write", d, 0);

    // R9: underrun after the stream ends
    @(negedge clk);
    shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    check(underrun == 1'b1 && vid_valid == 1'b0, "R9 underrun after stream", underrun, 1);
    @(negedge clk);
    check(underrun == 1'b0, "R9 underrun one cycle", underrun, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule